// File: doc/BRIEF.md
# Fixed-Point Time Counter with Programmable Increment

This block keeps a 64-bit time value that advances by a software-programmed increment each time its oscillator tick pulse is seen. The value is a scaled fixed-point quantity. A consumer turns it into nanoseconds with one right shift, by the shift amount that the block publishes for the present link speed. Software trims the clock frequency by a few parts per billion when it rewrites the increment. Each new increment starts with the next tick, and the time already accumulated is left as it is.

Software reaches the block through a small word-wide register port with four addresses: time low word, time high word, increment and shift. A 64-bit time value passes through this 32-bit port without tearing. Reading the low word captures the high word into a shadow register, and a later high-word read returns that captured value. A write to the low word is only held. The following high-word write loads the full 64-bit value in a single cycle. A 2-bit link-speed input picks the default increment and shift. Those defaults are loaded at reset and again whenever the link speed changes. A parameter picks one of two register variants. The wide variant has a 31-bit increment field. The narrow variant has a 24-bit increment field, a period-enable bit at bit 24, and defaults that are scaled down by 2^7.

Top module: `tc_time_counter`

## Requirements
- R1: After reset the time is zero, `reg_rvalid` is low, and the increment and shift registers hold the defaults for the current `link_speed`.
- R2: On a cycle with `osc_tick` high and no high-word write, the time becomes the old time plus the effective increment. With neither a tick nor a high-word write, the time holds.
- R3: The addition wraps modulo 2^64, so 0xFFFFFFFF_F0000000 plus 0x20000000 gives 0x00000000_10000000.
- R4: A write to address 0 (time low) only stages the word and leaves the time unchanged. A write to address 1 (time high) loads {high word, staged low word} in one cycle. That load wins over a tick in the same cycle.
- R5: Writing zero to the low word and then zero to the high word clears the time to zero.
- R6: A read of address 0 returns the current low word and copies the current high word into a shadow. A read of address 1 returns the shadow, even after the counter has carried into the high word in the meantime.
- R7: A write to address 2 (increment) leaves the time unchanged. A tick in the same cycle still adds the old increment, and the new increment is used from the next tick on.
- R8: Link-speed codes are 0 = 10 Gb/s or no link, 1 = 1 Gb/s, 2 = 100 Mb/s, 3 = same as 0. In the wide variant the default increment/shift are 0x66666666/28, 0x40000000/24 and 0x50000000/21 for codes 0, 1 and 2.
- R9: A change of `link_speed` reloads the increment and shift defaults for the new code one cycle later, and replaces any increment software has written.
- R10: In the narrow variant the increment register holds a 24-bit increment in bits 23:0 and a period-enable bit at bit 24. Reset loads that bit as 1, and a tick adds the increment only while the bit is 1. The defaults are the wide values shifted right by 7, with the shift reduced by 7 (code 0: 0x01CCCCCC, shift 21).
- R11: A read pulse on `reg_rd` returns `reg_rdata` with `reg_rvalid` high in the next cycle only. Address 3 returns the shift amount in bits 4:0.
- R12: In the wide variant the increment register keeps bits 30:0 of a write, and bit 31 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| link_speed | input | 2 | Link-speed code for default selection |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 time low, 1 time high, 2 increment, 3 shift |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| time_value | output | 64 | Current accumulated time |

## Verification
A corrupted accumulator or adder carry shows up on `time_value` on the very tick after it happens, and it stays wrong for every later tick, since the error is never corrected. A bad shadow capture stays hidden until the high-word read that follows a low-word read, so the bench lets the counter carry into the high word between those two reads. Mistakes in the increment register appear only when a tick arrives, or when the register is read back through address 2. For that reason every increment change is followed both by a readback and by a counted number of ticks.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    LINK_10G  = 2'd0,
    LINK_1G   = 2'd1,
    LINK_100M = 2'd2,
    LINK_ALT  = 2'd3
  } link_e;

  typedef enum logic [1:0] {
    A_TLO = 2'd0,
    A_THI = 2'd1,
    A_INC = 2'd2,
    A_SHF = 2'd3
  } reg_addr_e;

  localparam int NARROW_DROP = 7;
  localparam int PERIOD_BIT  = 24;

  function automatic logic [31:0] dflt_inc(input logic [1:0] spd, input logic narrow);
    logic [31:0] base;
    case (spd)
      2'd1:    base = 32'h4000_0000;
      2'd2:    base = 32'h5000_0000;
      default: base = 32'h6666_6666;
    endcase
    if (narrow) dflt_inc = (base >> NARROW_DROP) | (32'd1 << PERIOD_BIT);
    else        dflt_inc = base;
  endfunction

  function automatic logic [4:0] dflt_shift(input logic [1:0] spd, input logic narrow);
    logic [4:0] s;
    case (spd)
      2'd1:    s = 5'd24;
      2'd2:    s = 5'd21;
      default: s = 5'd28;
    endcase
    dflt_shift = narrow ? s - 5'(NARROW_DROP) : s;
  endfunction

endpackage

// File: rtl/tc_incr_reg.sv
module tc_incr_reg
  import tc_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int W      = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   link_speed,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] inc_word,
  output logic [4:0]   shift,
  output logic [W-1:0] step
);
  localparam int INC_W = NARROW ? 24 : 31;
  localparam logic [W-1:0] FIELD_MASK = (W'(1) << INC_W) - W'(1);
  localparam logic [W-1:0] REG_MASK   = NARROW ? (FIELD_MASK | (W'(1) << PERIOD_BIT)) : FIELD_MASK;

  logic [1:0] link_q;
  logic       link_chg;

  assign link_chg = (link_speed != link_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q   <= link_speed;
      inc_word <= W'(dflt_inc(link_speed, NARROW)) & REG_MASK;
      shift    <= dflt_shift(link_speed, NARROW);
    end else begin
      link_q <= link_speed;
      if (link_chg) begin
        inc_word <= W'(dflt_inc(link_speed, NARROW)) & REG_MASK;
        shift    <= dflt_shift(link_speed, NARROW);
      end else if (wr_en) begin
        inc_word <= wdata & REG_MASK;
      end
    end
  end

  generate
    if (NARROW) begin : g_narrow
      assign step = inc_word[PERIOD_BIT] ? (inc_word & FIELD_MASK) : '0;
    end else begin : g_wide
      assign step = inc_word & FIELD_MASK;
    end
  endgenerate

  // R9: a link change reloads the defaults of the new code
  assert_link_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg |=> (inc_word == (W'(dflt_inc($past(link_speed), NARROW)) & REG_MASK)));

  // R7: without a write or link change the increment holds
  assert_inc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !link_chg) |=> $stable(inc_word));

endmodule

// File: rtl/tc_accum.sv
module tc_accum #(
  parameter int TIME_W = 64,
  parameter int W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [W-1:0]      step,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [W-1:0]      wdata,
  output logic [TIME_W-1:0] time_q
);
  localparam int HI_W = TIME_W - W;

  logic [W-1:0]      staged;
  logic [TIME_W-1:0] step_ext;

  assign step_ext = {{HI_W{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= '0;
      time_q <= '0;
    end else begin
      if (lo_wr) staged <= wdata;
      if (hi_wr)     time_q <= {wdata[HI_W-1:0], staged};
      else if (tick) time_q <= time_q + step_ext;
    end
  end

  // R2: idle cycles keep the time
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hi_wr) |=> $stable(time_q));

  // R2 / R3: a tick adds the step modulo 2^TIME_W
  assert_tick_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hi_wr) |=> (time_q == $past(time_q) + $past(step_ext)));

  // R4: high-word write loads the staged word with the new high word
  assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (time_q == {$past(wdata[HI_W-1:0]), $past(staged)}));

  // R4: writing the low word alone never moves the time
  assert_lo_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !hi_wr && !tick) |=> $stable(time_q));

endmodule

// File: rtl/tc_read_port.sv
module tc_read_port
  import tc_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [TIME_W-1:0] time_q,
  input  logic [W-1:0]      inc_word,
  input  logic [4:0]        shift,
  output logic [W-1:0]      rdata,
  output logic              rvalid
);
  localparam int HI_W = TIME_W - W;

  logic [HI_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        case (reg_addr_e'(addr))
          A_TLO: begin
            rdata  <= time_q[W-1:0];
            shadow <= time_q[TIME_W-1:W];
          end
          A_THI:   rdata <= W'(shadow);
          A_INC:   rdata <= inc_word;
          default: rdata <= {{(W-5){1'b0}}, shift};
        endcase
      end
    end
  end

  // R6: a low-word read captures the high word
  assert_shadow_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=> (shadow == $past(time_q[TIME_W-1:W])));

  // R11: read data valid exactly one cycle after the strobe
  assert_rvalid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

endmodule

// File: rtl/tc_time_counter.sv
module tc_time_counter
  import tc_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int TIME_W = 64,
  parameter int W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [1:0]        link_speed,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              reg_rvalid,
  output logic [TIME_W-1:0] time_value
);
  logic         lo_wr, hi_wr, inc_wr;
  logic [W-1:0] inc_word, step;
  logic [4:0]   shift;

  assign lo_wr  = reg_wr && (reg_addr == A_TLO);
  assign hi_wr  = reg_wr && (reg_addr == A_THI);
  assign inc_wr = reg_wr && (reg_addr == A_INC);

  tc_incr_reg #(.NARROW(NARROW), .W(W)) u_inc (
    .clk(clk), .rst_n(rst_n), .link_speed(link_speed), .wr_en(inc_wr),
    .wdata(reg_wdata), .inc_word(inc_word), .shift(shift), .step(step)
  );

  tc_accum #(.TIME_W(TIME_W), .W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .step(step), .lo_wr(lo_wr),
    .hi_wr(hi_wr), .wdata(reg_wdata), .time_q(time_value)
  );

  tc_read_port #(.TIME_W(TIME_W), .W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .addr(reg_addr), .time_q(time_value),
    .inc_word(inc_word), .shift(shift), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

endmodule

// File: tb/test_tc_time_counter.sv
module test_tc_time_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        tick [2];
  logic [1:0]  spd [2];
  logic        wr [2];
  logic        rd [2];
  logic [1:0]  addr [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic        rvalid [2];
  logic [63:0] tval [2];

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  tc_time_counter i_tc_time_counter (
    .clk(clk), .rst_n(rst_n), .osc_tick(tick[0]), .link_speed(spd[0]),
    .reg_wr(wr[0]), .reg_rd(rd[0]), .reg_addr(addr[0]), .reg_wdata(wdata[0]),
    .reg_rdata(rdata[0]), .reg_rvalid(rvalid[0]), .time_value(tval[0])
  );

  tc_time_counter #(.NARROW(1'b1)) i_narrow (
    .clk(clk), .rst_n(rst_n), .osc_tick(tick[1]), .link_speed(spd[1]),
    .reg_wr(wr[1]), .reg_rd(rd[1]), .reg_addr(addr[1]), .reg_wdata(wdata[1]),
    .reg_rdata(rdata[1]), .reg_rvalid(rvalid[1]), .time_value(tval[1])
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input int s, input logic [1:0] a, input logic [31:0] d, input bit with_tick = 0);
    wr[s] = 1; addr[s] = a; wdata[s] = d; tick[s] = with_tick;
    @(negedge clk);
    wr[s] = 0; tick[s] = 0;
  endtask

  task automatic do_rd(input int s, input logic [1:0] a, output logic [31:0] d);
    rd[s] = 1; addr[s] = a;
    @(negedge clk);
    rd[s] = 0;
    chk("R11 rvalid", {63'd0, rvalid[s]}, 64'd1);
    d = rdata[s];
  endtask

  task automatic do_tick(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      tick[s] = 1;
      @(negedge clk);
      tick[s] = 0;
    end
  endtask

  task automatic set_time(input int s, input logic [63:0] v);
    do_wr(s, 2'd0, v[31:0]);
    do_wr(s, 2'd1, v[63:32]);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 time", tval[0], 64'd0);
    chk("R1 rvalid", {63'd0, rvalid[0]}, 64'd0);
    do_rd(0, 2'd2, d); chk("R1 R8 inc 10G", {32'd0, d}, 64'h6666_6666);
    do_rd(0, 2'd3, d); chk("R1 R8 shift 10G", {32'd0, d}, 64'd28);
    @(negedge clk);
    chk("R11 single valid", {63'd0, rvalid[0]}, 64'd0);
  endtask

  task automatic t_ticks;
    logic [31:0] d;
    do_wr(0, 2'd2, 32'h0000_1000);
    chk("R7 inc write keeps time", tval[0], 64'd0);
    do_tick(0, 5);
    chk("R2 five ticks", tval[0], 64'h5000);
    repeat (3) @(negedge clk);
    chk("R2 hold without tick", tval[0], 64'h5000);
    do_wr(0, 2'd2, 32'hFFFF_FFFF);
    do_rd(0, 2'd2, d); chk("R12 bit31 reads 0", {32'd0, d}, 64'h7FFF_FFFF);
  endtask

  task automatic t_write_commit;
    do_wr(0, 2'd2, 32'h10);
    set_time(0, 64'h1234_5678_9ABC_DEF0);
    chk("R4 commit", tval[0], 64'h1234_5678_9ABC_DEF0);
    do_wr(0, 2'd0, 32'h1111_1111);
    chk("R4 low write staged only", tval[0], 64'h1234_5678_9ABC_DEF0);
    do_wr(0, 2'd1, 32'h2222_2222, 1);
    chk("R4 commit beats tick", tval[0], 64'h2222_2222_1111_1111);
    set_time(0, 64'd0);
    chk("R5 clear", tval[0], 64'd0);
  endtask

  task automatic t_wrap;
    do_wr(0, 2'd2, 32'h2000_0000);
    set_time(0, 64'hFFFF_FFFF_F000_0000);
    do_tick(0, 1);
    chk("R3 wrap", tval[0], 64'h0000_0000_1000_0000);
  endtask

  task automatic t_shadow;
    logic [31:0] d;
    do_wr(0, 2'd2, 32'h10);
    set_time(0, 64'h0000_0001_FFFF_FFF0);
    do_rd(0, 2'd0, d); chk("R6 low word", {32'd0, d}, 64'hFFFF_FFF0);
    do_tick(0, 1);
    chk("R2 carry", tval[0], 64'h0000_0002_0000_0000);
    do_rd(0, 2'd1, d); chk("R6 shadow high", {32'd0, d}, 64'd1);
    do_rd(0, 2'd1, d); chk("R6 shadow repeat", {32'd0, d}, 64'd1);
    do_rd(0, 2'd0, d); chk("R6 low again", {32'd0, d}, 64'd0);
    do_rd(0, 2'd1, d); chk("R6 new high", {32'd0, d}, 64'd2);
  endtask

  task automatic t_inc_switch;
    do_wr(0, 2'd2, 32'h100);
    set_time(0, 64'd0);
    do_wr(0, 2'd2, 32'h5, 1);
    chk("R7 old inc same cycle", tval[0], 64'h100);
    do_tick(0, 2);
    chk("R7 new inc after", tval[0], 64'h10A);
  endtask

  task automatic t_link;
    logic [31:0] d;
    do_wr(0, 2'd2, 32'h77);
    spd[0] = 2'd1; @(negedge clk);
    do_rd(0, 2'd2, d); chk("R9 R8 inc 1G", {32'd0, d}, 64'h4000_0000);
    do_rd(0, 2'd3, d); chk("R9 R8 shift 1G", {32'd0, d}, 64'd24);
    spd[0] = 2'd2; @(negedge clk);
    do_rd(0, 2'd2, d); chk("R8 inc 100M", {32'd0, d}, 64'h5000_0000);
    do_rd(0, 2'd3, d); chk("R8 shift 100M", {32'd0, d}, 64'd21);
    spd[0] = 2'd3; @(negedge clk);
    do_rd(0, 2'd2, d); chk("R8 code3 as 10G", {32'd0, d}, 64'h6666_6666);
  endtask

  task automatic t_narrow;
    logic [31:0] d;
    do_rd(1, 2'd2, d); chk("R10 narrow default", {32'd0, d}, 64'h01CC_CCCC);
    do_rd(1, 2'd3, d); chk("R10 narrow shift", {32'd0, d}, 64'd21);
    do_tick(1, 1);
    chk("R10 narrow tick", tval[1], 64'h00CC_CCCC);
    do_wr(1, 2'd2, 32'h0000_00FF);
    do_tick(1, 1);
    chk("R10 period bit clear", tval[1], 64'h00CC_CCCC);
    do_wr(1, 2'd2, 32'h0100_00FF);
    do_tick(1, 1);
    chk("R10 period bit set", tval[1], 64'h00CC_CDCB);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      tick[s] = 0; spd[s] = 2'd0; wr[s] = 0; rd[s] = 0; addr[s] = 0; wdata[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ticks();
    t_write_commit();
    t_wrap();
    t_shadow();
    t_inc_switch();
    t_link();
    t_narrow();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule